// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the configuration front end of a legacy-style eight-input programmable interrupt controller. It watches a byte-wide I/O-style write stream, reacts to two ports (an even base port and the odd port above it), and runs the four-word initialization sequence. That sequence starts with a base-port write that has data bit 4 set, and the next three odd-port writes complete it. The block stores the vector base, the cascade identity and the processor-mode bit, and it drives the mask, trigger, priority and status-select state that the rest of the controller uses.

Each write arrives as a valid/ready beat. The sequencer never applies back-pressure: `wr_ready` is tied high, so every cycle with `wr_valid` high is one accepted write. The instance's port pair is set by the `BASE_PORT` parameter. The master sits at 20h/21h and the slave at A0h/A1h.

When the block is idle, odd-port writes are not initialization words. They are passed on as a one-cycle operation-command strobe. A synchronous reset leaves the block uninitialized: all inputs are masked and `init_ready` is low.

Top module: `pic_init_seq`

## Requirements
- R1: After reset the block's outputs hold these values:
  - `init_ready`=0, `irq_mask`=FFh, `trig_edge`=0, `prio_low`=7, `slave_addr`=7
  - `spec_mask`=0, `stat_isr`=0, `vec_base`=0, `slave_id`=0, `upm_mode`=0, `ocw_valid`=0
- R2: An accepted write to `BASE_PORT` with data bit 4 = 1 is the first initialization word. One cycle later the block shows these values:
  - `irq_mask`=00h and `trig_edge`=1 (rising-edge detection)
  - `prio_low`=7 and `slave_addr`=7
  - `spec_mask`=0 and `stat_isr`=0 (status read selects the request register)
  - `init_ready`=0
- R3: The first odd-port (`BASE_PORT`+1) write after the first word loads data bits [7:3] into `vec_base`.
- R4: The second odd-port write after the first word loads the whole byte into `slave_id`.
- R5: The third odd-port write after the first word loads data bit 0 into `upm_mode` and raises `init_ready` on the next cycle. The sequence is then complete.
- R6: An odd-port write while no sequence is in progress changes no configuration output. It produces `ocw_valid` high for exactly one cycle, with `ocw_data` equal to the written byte. No strobe is produced during a sequence.
- R7: A base-port write with data bit 4 = 0, or a write to any other address, changes no output.
- R8: A first word arriving in the middle of a sequence restarts it. The next odd write goes to `vec_base`.
- R9: `wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_addr | input | 8 | I/O port address |
| wr_data | input | 8 | Write byte |
| init_ready | output | 1 | Initialization sequence completed |
| irq_mask | output | 8 | Interrupt mask register |
| trig_edge | output | 1 | 1 = rising-edge request detection |
| prio_low | output | 3 | Input holding lowest priority |
| slave_addr | output | 3 | Slave-mode address |
| spec_mask | output | 1 | Special mask mode enable |
| stat_isr | output | 1 | Status read select, 0 = request register |
| vec_base | output | 5 | Upper five vector bits |
| slave_id | output | 8 | Cascade identification code |
| upm_mode | output | 1 | Processor-mode bit from the fourth word |
| ocw_valid | output | 1 | Operation-command write strobe |
| ocw_data | output | 8 | Operation-command byte |

## Verification
The bench restarts the sequence at several points. A design that kept its step counter on a restart would load the wrong register, for example the slave identity instead of the vector base. It also writes the base port with bit 4 clear, and a design that decoded the port alone would restart and drop `init_ready`. Odd writes made while idle must produce a strobe and leave `vec_base` alone; a design that did not gate on the sequence state would corrupt the stored base. The one-cycle width of the strobe and the defaults forced by the first word are checked against reset values chosen to differ from them.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_W2   = 2'd1,
    ST_W3   = 2'd2,
    ST_W4   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pic_port_decode.sv
module pic_port_decode #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BASE_PORT = 32
) (
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              start_hit,
  output logic              odd_hit
);
  localparam logic [ADDR_W-1:0] EVEN_A = ADDR_W'(BASE_PORT & ~1);
  localparam logic [ADDR_W-1:0] ODD_A  = ADDR_W'(BASE_PORT | 1);
  localparam int START_BIT = 4;

  always_comb begin
    start_hit = acc && (addr == EVEN_A) && data[START_BIT];
    odd_hit   = acc && (addr == ODD_A);
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_init_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_hit,
  input  logic    odd_hit,
  output seq_st_e state,
  output logic    ld_w2,
  output logic    ld_w3,
  output logic    ld_w4,
  output logic    cmd_hit
);
  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else if (start_hit) state <= ST_W2;
    else if (odd_hit) begin
      case (state)
        ST_W2:   state <= ST_W3;
        ST_W3:   state <= ST_W4;
        ST_W4:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ld_w2   = odd_hit && (state == ST_W2);
    ld_w3   = odd_hit && (state == ST_W3);
    ld_w4   = odd_hit && (state == ST_W4);
    cmd_hit = odd_hit && (state == ST_IDLE);
  end

  a_r8_restart_to_w2: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> state == ST_W2);
  a_r5_complete_idle: assert property (@(posedge clk) disable iff (rst)
    (ld_w4 && !start_hit) |=> state == ST_IDLE);
endmodule

// File: rtl/pic_init_regs.sv
module pic_init_regs #(
  parameter int N_IRQ  = 8,
  parameter int DATA_W = 8,
  parameter int VB_W   = DATA_W - 3,
  parameter int PRIO_W = $clog2(N_IRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_hit,
  input  logic              ld_w2,
  input  logic              ld_w3,
  input  logic              ld_w4,
  input  logic [DATA_W-1:0] data,
  output logic              init_ready,
  output logic [N_IRQ-1:0]  irq_mask,
  output logic              trig_edge,
  output logic [PRIO_W-1:0] prio_low,
  output logic [2:0]        slave_addr,
  output logic              spec_mask,
  output logic              stat_isr,
  output logic [VB_W-1:0]   vec_base,
  output logic [DATA_W-1:0] slave_id,
  output logic              upm_mode
);
  localparam logic [PRIO_W-1:0] LOWEST = PRIO_W'(N_IRQ - 1);
  localparam logic [2:0]        DEF_SA = 3'd7;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_ready <= 1'b0;
      irq_mask   <= '1;
      trig_edge  <= 1'b0;
      prio_low   <= LOWEST;
      slave_addr <= DEF_SA;
      spec_mask  <= 1'b0;
      stat_isr   <= 1'b0;
      vec_base   <= '0;
      slave_id   <= '0;
      upm_mode   <= 1'b0;
    end else if (start_hit) begin
      init_ready <= 1'b0;
      irq_mask   <= '0;
      trig_edge  <= 1'b1;
      prio_low   <= LOWEST;
      slave_addr <= DEF_SA;
      spec_mask  <= 1'b0;
      stat_isr   <= 1'b0;
    end else begin
      if (ld_w2) vec_base <= data[DATA_W-1:3];
      if (ld_w3) slave_id <= data;
      if (ld_w4) begin
        upm_mode   <= data[0];
        init_ready <= 1'b1;
      end
    end
  end

  a_r2_start_defaults: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> (irq_mask == '0) && trig_edge && (prio_low == LOWEST) &&
                  (slave_addr == DEF_SA) && !spec_mask && !stat_isr && !init_ready);
  a_r3_vec_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_w2 |=> $stable(vec_base));
  a_r4_sid_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_w3 |=> $stable(slave_id));
  a_r5_ready_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(init_ready) |-> $past(ld_w4));
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int BASE_PORT = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int N_IRQ     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              init_ready,
  output logic [N_IRQ-1:0]  irq_mask,
  output logic              trig_edge,
  output logic [$clog2(N_IRQ)-1:0] prio_low,
  output logic [2:0]        slave_addr,
  output logic              spec_mask,
  output logic              stat_isr,
  output logic [DATA_W-4:0] vec_base,
  output logic [DATA_W-1:0] slave_id,
  output logic              upm_mode,
  output logic              ocw_valid,
  output logic [DATA_W-1:0] ocw_data
);
  localparam logic [ADDR_W-1:0] ODD_A = ADDR_W'(BASE_PORT | 1);

  logic    acc, start_hit, odd_hit, ld_w2, ld_w3, ld_w4, cmd_hit;
  seq_st_e state;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid && wr_ready;

  pic_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_PORT(BASE_PORT)) u_dec (
    .acc(acc), .addr(wr_addr), .data(wr_data),
    .start_hit(start_hit), .odd_hit(odd_hit)
  );

  pic_init_fsm u_fsm (
    .clk(clk), .rst(rst), .start_hit(start_hit), .odd_hit(odd_hit),
    .state(state), .ld_w2(ld_w2), .ld_w3(ld_w3), .ld_w4(ld_w4), .cmd_hit(cmd_hit)
  );

  pic_init_regs #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .start_hit(start_hit),
    .ld_w2(ld_w2), .ld_w3(ld_w3), .ld_w4(ld_w4), .data(wr_data),
    .init_ready(init_ready), .irq_mask(irq_mask), .trig_edge(trig_edge),
    .prio_low(prio_low), .slave_addr(slave_addr), .spec_mask(spec_mask),
    .stat_isr(stat_isr), .vec_base(vec_base), .slave_id(slave_id),
    .upm_mode(upm_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ocw_valid <= 1'b0;
      ocw_data  <= '0;
    end else begin
      ocw_valid <= cmd_hit;
      if (cmd_hit) ocw_data <= wr_data;
    end
  end

  a_r6_ocw_source: assert property (@(posedge clk) disable iff (rst)
    ocw_valid |-> $past(wr_valid && (wr_addr == ODD_A)));
  a_r6_ocw_in_seq: assert property (@(posedge clk) disable iff (rst)
    (odd_hit && state != ST_IDLE) |=> !ocw_valid);
endmodule

// File: tb/pic_init_seq_test.sv
module pic_init_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       init_ready, trig_edge, spec_mask, stat_isr, upm_mode, ocw_valid;
  logic [7:0] irq_mask, slave_id, ocw_data;
  logic [2:0] prio_low, slave_addr;
  logic [4:0] vec_base;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pic_init_seq uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .init_ready(init_ready),
    .irq_mask(irq_mask), .trig_edge(trig_edge), .prio_low(prio_low),
    .slave_addr(slave_addr), .spec_mask(spec_mask), .stat_isr(stat_isr),
    .vec_base(vec_base), .slave_id(slave_id), .upm_mode(upm_mode),
    .ocw_valid(ocw_valid), .ocw_data(ocw_data)
  );

  // {addr, data, ready, vec_base, slave_id, upm, ocw_valid}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {8'h20, 8'h11, 1'b0, 5'd0,  8'h00, 1'b0, 1'b0},  // R2 start
    {8'h21, 8'h48, 1'b0, 5'd9,  8'h00, 1'b0, 1'b0},  // R3
    {8'h21, 8'h04, 1'b0, 5'd9,  8'h04, 1'b0, 1'b0},  // R4
    {8'h21, 8'h01, 1'b1, 5'd9,  8'h04, 1'b1, 1'b0},  // R5
    {8'h21, 8'hAA, 1'b1, 5'd9,  8'h04, 1'b1, 1'b1},  // R6 idle strobe
    {8'h20, 8'h08, 1'b1, 5'd9,  8'h04, 1'b1, 1'b0},  // R7 bit4 clear
    {8'h55, 8'h13, 1'b1, 5'd9,  8'h04, 1'b1, 1'b0},  // R7 other port
    {8'h20, 8'h10, 1'b0, 5'd9,  8'h04, 1'b1, 1'b0},  // R2 restart
    {8'h21, 8'hF8, 1'b0, 5'd31, 8'h04, 1'b1, 1'b0},  // R3
    {8'h20, 8'h19, 1'b0, 5'd31, 8'h04, 1'b1, 1'b0},  // R8 mid restart
    {8'h21, 8'h20, 1'b0, 5'd4,  8'h04, 1'b1, 1'b0},  // R8 goes to vec
    {8'h21, 8'h02, 1'b0, 5'd4,  8'h02, 1'b1, 1'b0},  // R4
    {8'h21, 8'h00, 1'b1, 5'd4,  8'h02, 1'b0, 1'b0}   // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [16:0] cfg();
    return {irq_mask, trig_edge, prio_low, slave_addr, spec_mask, stat_isr};
  endfunction

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [16:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg() == {8'hFF, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0}, "R1 cfg", 32'(cfg()),
        32'({8'hFF, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0}));
    chk({init_ready, vec_base, slave_id, upm_mode, ocw_valid} == '0, "R1 status",
        32'({init_ready, vec_base, slave_id, upm_mode, ocw_valid}), 0);
    chk(wr_ready == 1'b1, "R9 ready", 32'(wr_ready), 1);

    // R6: odd write before any sequence gives strobe, no config change
    wr(8'h21, 8'h5C);
    chk(ocw_valid && ocw_data == 8'h5C && vec_base == 0, "R6 pre-init strobe",
        32'({ocw_valid, ocw_data, vec_base}), 32'({1'b1, 8'h5C, 5'd0}));
    @(negedge clk);
    chk(!ocw_valid, "R6 strobe one cycle", 32'(ocw_valid), 0);

    // R7: bit4 clear on base port before init leaves mask set
    wr(8'h20, 8'h0B);
    chk(irq_mask == 8'hFF && !trig_edge, "R7 no start", 32'({irq_mask, trig_edge}), 32'h1FE);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      wr(v[31:24], v[23:16]);
      chk({init_ready, vec_base, slave_id, upm_mode, ocw_valid} == v[15:0],
          $sformatf("R2-table step %0d (R3 R4 R5 R6 R7 R8)", i),
          32'({init_ready, vec_base, slave_id, upm_mode, ocw_valid}), 32'(v[15:0]));
      if (v[0]) chk(ocw_data == v[23:16], "R6 data", 32'(ocw_data), 32'(v[23:16]));
      if (v[31:24] == 8'h20 && v[20])
        chk(cfg() == {8'h00, 1'b1, 3'd7, 3'd7, 1'b0, 1'b0}, "R2 defaults",
            32'(cfg()), 32'({8'h00, 1'b1, 3'd7, 3'd7, 1'b0, 1'b0}));
    end

    // R7: ignored writes keep full config
    snap = cfg();
    wr(8'h20, 8'hEF);
    wr(8'hA1, 8'h33);
    chk(cfg() == snap && init_ready && !ocw_valid, "R7 ignored",
        32'({cfg(), init_ready}), 32'({snap, 1'b1}));

    // R1: reset mid sequence then restore
    wr(8'h20, 8'h10);
    wr(8'h21, 8'h80);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(!init_ready && vec_base == 0 && irq_mask == 8'hFF, "R1 reset again",
        32'({init_ready, vec_base, irq_mask}), 32'h0FF);
    wr(8'h21, 8'h77);
    chk(ocw_valid && vec_base == 0, "R6 idle after reset",
        32'({ocw_valid, vec_base}), 32'h20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule